// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block watches a bank of already-synchronized general-purpose input pins and turns activity on them into interrupt requests. Each pin carries two configuration bits, a level/edge selector and a polarity inverter, which together choose one of four trigger modes: rising edge, falling edge, low level or high level. A detected trigger sets that pin's status bit. Status bits are grouped into words of `WORD_W` bits. Software clears them by writing ones. A parallel set of enable words decides which pins may drive the shared interrupt line.

A per-pin ownership input marks pins that firmware has kept for itself. Such a pin never raises status, whatever its configuration. The combined interrupt output is registered, and it stays high while any pin has both status and enable set. Alongside it the block reports the lowest-numbered pin that is pending and enabled, found by scanning words upward from pin 0. Address decode belongs to the surrounding register bank, which hands this unit word-select indices and write strobes.

Top module: `gpio_irq_sense`

## Requirements
- R1: With level-select 0 and invert 0 (mode code 00), a pin's status bit is set at the clock edge where its input is 1 and was 0 at the previous edge.
- R2: With level-select 0 and invert 1 (mode code 01), a pin's status bit is set at the clock edge where its input is 0 and was 1 at the previous edge.
- R3: With level-select 1 and invert 0 (mode code 10), a pin's status bit is set at every clock edge where its input is 0.
- R4: With level-select 1 and invert 1 (mode code 11), a pin's status bit is set at every clock edge where its input is 1.
- R5: Status bit i of word w belongs to pin w*WORD_W+i. A status write to word w clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Writing all ones clears the whole word.
- R6: A trigger in the same cycle as a clearing write leaves the status bit set. A level trigger that stays active therefore re-sets the bit after each clear.
- R7: Status bits are set whether or not the pin is enabled. Enable words are written whole and read back. Bit positions beyond the last pin read 0 in both status and enable words.
- R8: `irq_out` goes to 1 one clock after some pin has both status and enable set, and returns to 0 one clock after no pin has both set.
- R9: `pend_idx` is registered with `irq_out` and gives the lowest pin number that has both status and enable set. It is 0 when no pin has both set.
- R10: A pin whose `host_owned` bit is 0 never sets its status bit.
- R11: After reset all status bits, enable bits, `irq_out` and `pend_idx` are 0. The first clock after reset detects no edge, whatever value the input held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| trig_level | input | NUM_PINS | Per-pin level/edge select (1 = level) |
| trig_inv | input | NUM_PINS | Per-pin polarity invert |
| host_owned | input | NUM_PINS | 1 = pin may raise interrupts, 0 = kept by firmware |
| sts_wr_en | input | 1 | Write-one-to-clear strobe for the status word chosen by `wr_sel` |
| en_wr_en | input | 1 | Write strobe for the enable word chosen by `wr_sel` |
| wr_sel | input | WSEL_W | Word index for writes |
| wr_data | input | WORD_W | Write data |
| rd_sel | input | WSEL_W | Word index for reads |
| sts_rd_data | output | WORD_W | Status word selected by `rd_sel` |
| en_rd_data | output | WORD_W | Enable word selected by `rd_sel` |
| irq_out | output | 1 | Combined registered interrupt request |
| pend_idx | output | PIN_IDX_W | Lowest pending and enabled pin number |

## Verification
A stuck or mis-decoded sense stage shows up in the status word in the cycle after the stimulus edge. The bench sweeps every mode against every previous/current input pair on every pin, so a wrong mode decode or a swapped edge polarity cannot go unnoticed. A status bit that clears or fails to clear shows on the read port in the same cycle as the write. A mistake in the combine or scan stage shows one cycle later on `irq_out` and `pend_idx`. The bench checks both of those outputs on the exact cycles when they should rise and fall, and again after successive clears that move the lowest pending pin upward.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // {level_select, invert}
   typedef enum logic [1:0] {
      TRIG_RISE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_mode_e;

   // Returns 1 when the pin satisfies its trigger in this cycle.
   // Edge modes need one captured previous sample (armed) before firing.
   function automatic logic sense_hit(trig_mode_e mode, logic cur, logic prev, logic armed);
      logic hit;
      case (mode)
         TRIG_RISE: hit = armed & cur & ~prev;
         TRIG_FALL: hit = armed & ~cur & prev;
         TRIG_LOW:  hit = ~cur;
         default:   hit = cur;
      endcase
      return hit;
   endfunction

   // Number of real pins carried by word w.
   function automatic int live_bits(int num_pins, int word_w, int w);
      int rest;
      rest = num_pins - w * word_w;
      if (rest > word_w) rest = word_w;
      if (rest < 0) rest = 0;
      return rest;
   endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NUM_PINS = 95
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] trig_level,
   input  logic [NUM_PINS-1:0] trig_inv,
   input  logic [NUM_PINS-1:0] host_owned,
   output logic [NUM_PINS-1:0] set_evt
);
   import gpio_irq_pkg::*;

   logic [NUM_PINS-1:0] prev_q;
   logic                armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= pin_in;
         armed_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      trig_mode_e mode;
      assign mode       = trig_mode_e'({trig_level[i], trig_inv[i]});
      assign set_evt[i] = host_owned[i] & sense_hit(mode, pin_in[i], prev_q[i], armed_q);
   end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
   parameter int WORD_W    = 32,
   parameter int LIVE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_evt,
   input  logic              clr_we,
   input  logic              en_we,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] sts_q,
   output logic [WORD_W-1:0] en_q
);

   if (LIVE_BITS < 1 || LIVE_BITS > WORD_W) begin : g_bad_live
      $error("gpio_irq_word: LIVE_BITS must lie in 1..WORD_W");
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b < LIVE_BITS) begin : g_live
         logic s_q, e_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= 1'b0;
               e_q <= 1'b0;
            end else begin
               // a trigger wins over a simultaneous clear
               s_q <= set_evt[b] | (s_q & ~(clr_we & wr_data[b]));
               if (en_we) e_q <= wr_data[b];
            end
         end
         assign sts_q[b] = s_q;
         assign en_q[b]  = e_q;
      end else begin : g_pad
         logic pad_unused;
         assign pad_unused = set_evt[b] ^ wr_data[b];
         assign sts_q[b]   = 1'b0;
         assign en_q[b]    = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 32,
   parameter int PIN_IDX_W = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WORDS*WORD_W-1:0]   pend_vec,
   output logic                          irq_q,
   output logic [PIN_IDX_W-1:0]          idx_q
);
   localparam int LOW_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   logic [NUM_WORDS-1:0]            word_any;
   logic [NUM_WORDS-1:0][LOW_W-1:0] word_low;

   // stage one: lowest set bit inside each word
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] slice;
      logic [LOW_W-1:0]  low_c;
      assign slice = pend_vec[w*WORD_W +: WORD_W];
      always_comb begin
         low_c = '0;
         for (int b = WORD_W - 1; b >= 0; b--) begin
            if (slice[b]) low_c = LOW_W'(b);
         end
      end
      assign word_any[w] = |slice;
      assign word_low[w] = low_c;
   end

   // stage two: lowest word that has anything
   logic                 hit_c;
   logic [PIN_IDX_W-1:0] idx_c;

   always_comb begin
      hit_c = 1'b0;
      idx_c = '0;
      for (int w = NUM_WORDS - 1; w >= 0; w--) begin
         if (word_any[w]) begin
            hit_c = 1'b1;
            idx_c = PIN_IDX_W'(w * WORD_W) + PIN_IDX_W'(word_low[w]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         idx_q <= '0;
      end else begin
         irq_q <= hit_c;
         idx_q <= idx_c;
      end
   end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
   parameter  int NUM_PINS  = 95,
   parameter  int WORD_W    = 32,
   localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
   localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pin_in,
   input  logic [NUM_PINS-1:0]  trig_level,
   input  logic [NUM_PINS-1:0]  trig_inv,
   input  logic [NUM_PINS-1:0]  host_owned,
   input  logic                 sts_wr_en,
   input  logic                 en_wr_en,
   input  logic [WSEL_W-1:0]    wr_sel,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic [WSEL_W-1:0]    rd_sel,
   output logic [WORD_W-1:0]    sts_rd_data,
   output logic [WORD_W-1:0]    en_rd_data,
   output logic                 irq_out,
   output logic [PIN_IDX_W-1:0] pend_idx
);
   import gpio_irq_pkg::*;

   localparam int FLAT_W   = NUM_WORDS * WORD_W;
   localparam int PAD_BITS = FLAT_W - NUM_PINS;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_sense: NUM_PINS must be at least 1");
   end
   if (WORD_W < 1 || WORD_W > 32) begin : g_bad_word
      $error("gpio_irq_sense: WORD_W must lie in 1..32");
   end

   logic [NUM_PINS-1:0] set_evt;
   logic [FLAT_W-1:0]   set_flat;
   logic [FLAT_W-1:0]   sts_flat;
   logic [FLAT_W-1:0]   en_flat;
   logic [NUM_PINS-1:0] sts_live;
   logic [NUM_PINS-1:0] en_live;

   gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (pin_in),
      .trig_level (trig_level),
      .trig_inv   (trig_inv),
      .host_owned (host_owned),
      .set_evt    (set_evt)
   );

   if (PAD_BITS > 0) begin : g_pad
      assign set_flat = {{PAD_BITS{1'b0}}, set_evt};
   end else begin : g_nopad
      assign set_flat = set_evt;
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int LIVE = live_bits(NUM_PINS, WORD_W, w);
      logic hit_wr;
      assign hit_wr = (wr_sel == WSEL_W'(w));
      gpio_irq_word #(.WORD_W(WORD_W), .LIVE_BITS(LIVE)) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (set_flat[w*WORD_W +: WORD_W]),
         .clr_we  (sts_wr_en & hit_wr),
         .en_we   (en_wr_en & hit_wr),
         .wr_data (wr_data),
         .sts_q   (sts_flat[w*WORD_W +: WORD_W]),
         .en_q    (en_flat[w*WORD_W +: WORD_W])
      );
   end

   assign sts_live = sts_flat[NUM_PINS-1:0];
   assign en_live  = en_flat[NUM_PINS-1:0];

   always_comb begin
      sts_rd_data = '0;
      en_rd_data  = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rd_sel == WSEL_W'(w)) begin
            sts_rd_data = sts_flat[w*WORD_W +: WORD_W];
            en_rd_data  = en_flat[w*WORD_W +: WORD_W];
         end
      end
   end

   gpio_irq_prio #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .PIN_IDX_W (PIN_IDX_W)
   ) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_vec (sts_flat & en_flat),
      .irq_q    (irq_out),
      .idx_q    (pend_idx)
   );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
   parameter int NUM_PINS  = 95,
   parameter int WORD_W    = 32,
   parameter int WSEL_W    = 2,
   parameter int PIN_IDX_W = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PINS-1:0]  pin_in,
   input logic [NUM_PINS-1:0]  trig_level,
   input logic [NUM_PINS-1:0]  trig_inv,
   input logic [NUM_PINS-1:0]  host_owned,
   input logic                 sts_wr_en,
   input logic [WSEL_W-1:0]    wr_sel,
   input logic [WORD_W-1:0]    wr_data,
   input logic [NUM_PINS-1:0]  sts_live,
   input logic [NUM_PINS-1:0]  en_live,
   input logic                 irq_out,
   input logic [PIN_IDX_W-1:0] pend_idx
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int WI = i / WORD_W;
      localparam int BI = i % WORD_W;
      logic clr_i;
      assign clr_i = sts_wr_en && (wr_sel == WSEL_W'(WI)) && wr_data[BI];

      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_live[i] && !clr_i) |=> sts_live[i]);

      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !host_owned[i]) |=> !sts_live[i]);

      p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!host_owned[i] && !sts_live[i]) |=> !sts_live[i]);

      p_low_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (host_owned[i] && trig_level[i] && !trig_inv[i] && !pin_in[i]) |=> sts_live[i]);

      p_high_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (host_owned[i] && trig_level[i] && trig_inv[i] && pin_in[i]) |=> sts_live[i]);
   end

   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_live & en_live)) |=> irq_out);

   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sts_live & en_live)) |=> !irq_out);

   p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> (pend_idx == '0));

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
   .NUM_PINS  (NUM_PINS),
   .WORD_W    (WORD_W),
   .WSEL_W    (WSEL_W),
   .PIN_IDX_W (PIN_IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_in     (pin_in),
   .trig_level (trig_level),
   .trig_inv   (trig_inv),
   .host_owned (host_owned),
   .sts_wr_en  (sts_wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .sts_live   (sts_live),
   .en_live    (en_live),
   .irq_out    (irq_out),
   .pend_idx   (pend_idx)
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;
   localparam int CLK_P  = 10;
   localparam int NP     = 10;
   localparam int WW     = 4;
   localparam int NW     = (NP + WW - 1) / WW;
   localparam int SW     = (NW > 1) ? $clog2(NW) : 1;
   localparam int IW     = (NP > 1) ? $clog2(NP) : 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0, trig_level = '0, trig_inv = '0, host_owned = '1;
   logic          sts_wr_en = 1'b0, en_wr_en = 1'b0;
   logic [SW-1:0] wr_sel = '0, rd_sel = '0;
   logic [WW-1:0] wr_data = '0;
   logic [WW-1:0] sts_rd_data, en_rd_data;
   logic          irq_out;
   logic [IW-1:0] pend_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gpio_irq_sense #(.NUM_PINS(NP), .WORD_W(WW)) u_gpio_irq_sense (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_level(trig_level),
      .trig_inv(trig_inv), .host_owned(host_owned), .sts_wr_en(sts_wr_en),
      .en_wr_en(en_wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .sts_rd_data(sts_rd_data), .en_rd_data(en_rd_data), .irq_out(irq_out),
      .pend_idx(pend_idx)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic rd_sts(input int w, output logic [31:0] v);
      rd_sel = SW'(w);
      #1;
      v = 32'(sts_rd_data);
   endtask

   task automatic rd_en(input int w, output logic [31:0] v);
      rd_sel = SW'(w);
      #1;
      v = 32'(en_rd_data);
   endtask

   task automatic clr_word(input int w, input logic [WW-1:0] d);
      sts_wr_en = 1'b1; wr_sel = SW'(w); wr_data = d;
      tick();
      sts_wr_en = 1'b0;
   endtask

   task automatic set_en(input int w, input logic [WW-1:0] d);
      en_wr_en = 1'b1; wr_sel = SW'(w); wr_data = d;
      tick();
      en_wr_en = 1'b0;
   endtask

   // expected trigger from the mode table of R1..R4
   function automatic logic exp_hit(int m, logic a, logic b);
      case (m)
         0: return !a && b;
         1: return a && !b;
         2: return !b;
         default: return b;
      endcase
   endfunction

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      // R11: inputs high through reset, rising mode
      pin_in = '1;
      repeat (3) tick();
      for (int w = 0; w < NW; w++) begin
         rd_sts(w, v); chk("R11 reset status", v, 0);
         rd_en(w, v);  chk("R11 reset enable", v, 0);
      end
      chk("R11 reset irq", 32'(irq_out), 0);
      chk("R11 reset idx", 32'(pend_idx), 0);
      rst_n = 1'b1;
      repeat (3) tick();
      for (int w = 0; w < NW; w++) begin
         rd_sts(w, v); chk("R11 no edge after reset", v, 0);
      end

      // R1..R4 sweep: every mode, pin and (previous,current) pair
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < NP; p++) begin
            for (int t = 0; t < 4; t++) begin
               logic a, b, e;
               string tag;
               a = t[1]; b = t[0];
               e = exp_hit(m, a, b);
               tag = (m == 0) ? "R1 rising" : (m == 1) ? "R2 falling" :
                     (m == 2) ? "R3 low level" : "R4 high level";
               trig_level = '0; trig_inv = '0;
               trig_level[p] = m[1]; trig_inv[p] = m[0];
               pin_in = '0; pin_in[p] = a;
               tick(); tick();
               pin_in[p] = b;
               clr_word(p / WW, '1);
               rd_sts(p / WW, v);
               chk(tag, v, 32'(e) << (p % WW));
               chk("R7 status while disabled, irq low", 32'(irq_out), 0);
            end
         end
      end

      // R5 / R7: write-one-to-clear and padding
      trig_level = '0; trig_inv = '0; pin_in = '0;
      tick(); tick();
      for (int w = 0; w < NW; w++) clr_word(w, '1);
      pin_in = '1;
      tick();
      rd_sts(0, v); chk("R5 all set word0", v, 32'hF);
      rd_sts(2, v); chk("R7 status pad reads 0", v, 32'h3);
      clr_word(0, 4'b0101);
      rd_sts(0, v); chk("R5 clear selected bits", v, 32'hA);
      clr_word(0, 4'b0000);
      rd_sts(0, v); chk("R5 zero write keeps", v, 32'hA);
      clr_word(0, 4'b1111);
      rd_sts(0, v); chk("R5 all ones clears", v, 0);
      rd_sts(1, v); chk("R5 other word untouched", v, 32'hF);
      set_en(2, 4'hF);
      rd_en(2, v); chk("R7 enable pad reads 0", v, 32'h3);
      set_en(0, 4'h5);
      rd_en(0, v); chk("R7 enable readback", v, 32'h5);
      for (int w = 0; w < NW; w++) set_en(w, '0);

      // R8: registered interrupt timing
      pin_in = '0;
      tick(); tick();
      for (int w = 0; w < NW; w++) clr_word(w, '1);
      set_en(1, 4'b0100);
      pin_in[6] = 1'b1;
      tick();
      rd_sts(1, v); chk("R8 status set", v, 32'h4);
      chk("R8 irq one cycle later (still 0)", 32'(irq_out), 0);
      tick();
      chk("R8 irq rises", 32'(irq_out), 1);
      chk("R9 idx pin6", 32'(pend_idx), 6);
      clr_word(1, 4'b0100);
      rd_sts(1, v); chk("R5 cleared", v, 0);
      chk("R8 irq held one cycle", 32'(irq_out), 1);
      tick();
      chk("R8 irq falls", 32'(irq_out), 0);
      chk("R9 idx idle", 32'(pend_idx), 0);

      // R9: lowest pending enabled pin
      set_en(0, 4'b1000);
      set_en(1, 4'b0010);
      set_en(2, 4'b0010);
      pin_in[1] = 1'b1; pin_in[3] = 1'b1; pin_in[5] = 1'b1; pin_in[9] = 1'b1;
      tick(); tick();
      chk("R9 irq", 32'(irq_out), 1);
      chk("R9 lowest is 3", 32'(pend_idx), 3);
      clr_word(0, 4'b1000); tick();
      chk("R9 next is 5", 32'(pend_idx), 5);
      clr_word(1, 4'b0010); tick();
      chk("R9 next is 9", 32'(pend_idx), 9);
      clr_word(2, 4'b0010); tick();
      chk("R8 irq off, pin1 disabled", 32'(irq_out), 0);
      chk("R9 idx 0", 32'(pend_idx), 0);
      rd_sts(0, v); chk("R7 disabled pin keeps status", v, 32'h2);

      // R10: firmware-owned pin never sets
      for (int w = 0; w < NW; w++) clr_word(w, '1);
      for (int w = 0; w < NW; w++) set_en(w, '0);
      trig_level[2] = 1'b1; trig_inv[2] = 1'b1; host_owned[2] = 1'b0;
      trig_level[7] = 1'b1; trig_inv[7] = 1'b1;
      pin_in = '0; pin_in[2] = 1'b1; pin_in[7] = 1'b1;
      tick(); tick(); tick();
      rd_sts(0, v); chk("R10 owned pin blocked", v, 0);
      rd_sts(1, v); chk("R4 contrast pin set", v, 32'h8);
      host_owned[2] = 1'b1;
      tick();
      rd_sts(0, v); chk("R10 released pin sets", v, 32'h4);

      // R6: set wins over clear, level re-sets
      clr_word(1, '1);
      rd_sts(1, v); chk("R6 level re-sets after clear", v, 32'h8);
      pin_in[7] = 1'b0;
      clr_word(1, '1);
      rd_sts(1, v); chk("R6 clear sticks once level gone", v, 0);
      pin_in[4] = 1'b1;
      clr_word(1, '1);
      rd_sts(1, v); chk("R6 edge with clear stays set", v, 32'h1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule